// File: doc/BRIEF.md
# Sampling Delay Sweep Tuner

The tuner finds a safe sampling delay for a receive path whose timing drifts with the clock mode. It walks an 8-bit delay through every setting from 0 up to 255. For each setting it places the trial value in a delay word, raises a test request, and waits for an external agent to report whether a test transfer at that delay worked. Once every setting has been tried, it picks the longest unbroken stretch of passing settings and selects the centre of that stretch.

The delay word has two byte-wide fields. One feeds the command-path sampler and the other feeds the read-data sampler, and a mode input chooses which of the two is tuned. A delay word is stored for each timing mode. A sweep starts from the stored word of the selected mode. On success that entry is updated, and in every case the stored word is presented as the active delay word when the sweep ends. A configuration word is also held here. The tuner clears its compensation-enable field at the start of a sweep, because compensation must be off while the trial delays are applied.

Top module: `sweep_tuner`

## Requirements
- R1: After reset, every output is zero: cfg_word, test_req, test_dly, active_word, best_dly, tune_err, busy and tune_done.
- R2: A sweep issues exactly 256 test requests, one each for test_dly = 0, 1, ..., 255 in increasing order. Each request stays high, with test_dly stable, until test_done is seen. The next request is raised only after that.
- R3: While test_req is high, active_word holds the stored word of the selected timing mode with the trial delay placed in bits [15:8] when tune_data = 0 (command field), or in bits [23:16] when tune_data = 1 (read-data field). All other bits keep the stored value.
- R4: When a sweep starts, bits [27:24] of cfg_word are cleared and its other bits are kept. While idle, cfg_wr_en loads cfg_word from cfg_wr_data.
- R5: The result is E - (L - 1) / 2, using integer division, where L is the length of the longest run of passing settings and E is the last setting of that run. When runs are equally long, the earliest one wins.
- R6: A passing run that reaches setting 255 competes with an end of 255.
- R7: If no setting passes, tune_err = 1, best_dly = 0, the stored word of the mode is not changed, and active_word equals that stored word.
- R8: If any setting passes, tune_err = 0, best_dly is the result, and the stored word of the mode gets the result in the tuned field. active_word equals the updated word.
- R9: Stored words are kept per timing mode, with indices 0 to 8, and are loaded through ld_en/ld_mode/ld_word only while idle. A load while busy is ignored, and a sweep changes no entry other than its own.
- R10: tune_done is a one-cycle pulse, after which busy is low. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep (taken only while idle) |
| tune_data | input | 1 | 0 tunes the command field, 1 tunes the read-data field |
| mode_sel | input | 4 | Timing mode whose stored word is tuned |
| ld_en | input | 1 | Load a stored word (idle only) |
| ld_mode | input | 4 | Timing mode index for the load |
| ld_word | input | 32 | Word to store |
| cfg_wr_en | input | 1 | Write the configuration word (idle only) |
| cfg_wr_data | input | 32 | Configuration value to write |
| cfg_word | output | 32 | Configuration word with the compensation-enable field |
| test_req | output | 1 | Request a test transfer at test_dly |
| test_dly | output | 8 | Delay setting under test |
| test_done | input | 1 | Test transfer finished (one-cycle pulse) |
| test_pass | input | 1 | Test result, valid with test_done |
| active_word | output | 32 | Delay word currently applied |
| best_dly | output | 8 | Chosen delay of the last sweep |
| tune_err | output | 1 | Last sweep found no passing setting |
| busy | output | 1 | Sweep in progress |
| tune_done | output | 1 | One-cycle pulse at sweep end |

## Verification
The bench drives start on a falling edge. One clock edge later it checks busy and the cleared compensation field. The first request rises two edges after that. Each request is checked at the falling edge where it is first seen high: test_dly and the trial word in active_word are already valid there. The bench answers after a random wait of 0 to 2 cycles with a one-cycle test_done pulse. The request drops on the edge that samples test_done, and the next request rises one edge later. The edge that samples the final test_done moves the tuner to its finishing state. The next edge registers tune_done together with best_dly, tune_err and active_word, so all results are compared in the falling-edge window where tune_done is first seen high. The pulse shape and idle state are checked one cycle after that.

// File: rtl/sweep_tuner_pkg.sv
package sweep_tuner_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LOAD   = 3'd1,
      ST_ISSUE  = 3'd2,
      ST_WAIT   = 3'd3,
      ST_FINISH = 3'd4
   } tune_state_e;

   typedef enum logic {
      FLD_CMD  = 1'b0,
      FLD_DATA = 1'b1
   } field_sel_e;

endpackage

// File: rtl/sweep_tuner_store.sv
module sweep_tuner_store #(
   parameter int NUM_MODES = 9,
   parameter int WORD_W    = 32,
   parameter int MODE_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_idx,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [MODE_W-1:0] rd_idx,
   output logic [WORD_W-1:0] rd_word
);

   logic [WORD_W-1:0] ent_w [NUM_MODES];

   for (genvar g = 0; g < NUM_MODES; g++) begin : g_ent
      logic [WORD_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else if (wr_en && (wr_idx == MODE_W'(g))) begin
            ent_q <= wr_word;
         end
      end
      assign ent_w[g] = ent_q;
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_MODES; i++) begin
         if (rd_idx == MODE_W'(i)) rd_word = ent_w[i];
      end
   end

endmodule

// File: rtl/sweep_tuner_field.sv
module sweep_tuner_field #(
   parameter int WORD_W   = 32,
   parameter int DLY_W    = 8,
   parameter int CMD_LSB  = 8,
   parameter int DATA_LSB = 16
) (
   input  logic [WORD_W-1:0] word_in,
   input  logic [DLY_W-1:0]  dly,
   input  logic              use_data,
   output logic [WORD_W-1:0] word_out
);

   localparam int NUM_FLD = 2;

   logic [WORD_W-1:0] cand_w [NUM_FLD];

   for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
      localparam int LSB = (g == 0) ? CMD_LSB : DATA_LSB;
      logic [WORD_W-1:0] ins;
      always_comb begin
         ins                = word_in;
         ins[LSB +: DLY_W]  = dly;
      end
      assign cand_w[g] = ins;
   end

   assign word_out = use_data ? cand_w[1] : cand_w[0];

endmodule

// File: rtl/sweep_tuner_window.sv
module sweep_tuner_window #(
   parameter int DLY_W = 8,
   parameter int LEN_W = DLY_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic             pass,
   input  logic [DLY_W-1:0] idx,
   output logic             found,
   output logic [DLY_W-1:0] mid
);

   logic [LEN_W-1:0] run_q;
   logic [LEN_W-1:0] best_len_q;
   logic [DLY_W-1:0] best_end_q;
   logic [LEN_W-1:0] fin_len;
   logic [DLY_W-1:0] fin_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= '0;
         best_len_q <= '0;
         best_end_q <= '0;
      end else if (clear) begin
         run_q      <= '0;
         best_len_q <= '0;
         best_end_q <= '0;
      end else if (step) begin
         if (pass) begin
            run_q <= run_q + 1'b1;
         end else begin
            // strict compare: an equal later run never replaces the earlier one
            if (run_q > best_len_q) begin
               best_len_q <= run_q;
               best_end_q <= idx - 1'b1;
            end
            run_q <= '0;
         end
      end
   end

   // a run still open at the last index competes with that index as its end
   always_comb begin
      if (run_q > best_len_q) begin
         fin_len = run_q;
         fin_end = idx;
      end else begin
         fin_len = best_len_q;
         fin_end = best_end_q;
      end
   end

   assign found = (fin_len != '0);
   assign mid   = fin_end - DLY_W'((fin_len - 1'b1) >> 1);

   p_run_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !pass && !clear) |=> (run_q == '0));

   p_best_monotonic_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (best_len_q >= $past(best_len_q)));

endmodule

// File: rtl/sweep_tuner.sv
module sweep_tuner
   import sweep_tuner_pkg::*;
#(
   parameter int DLY_W     = 8,
   parameter int WORD_W    = 32,
   parameter int NUM_MODES = 9,
   parameter int CMD_LSB   = 8,
   parameter int DATA_LSB  = 16,
   parameter int COMP_LSB  = 24,
   parameter int COMP_W    = 4,
   localparam int MODE_W   = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tune_data,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic              ld_en,
   input  logic [MODE_W-1:0] ld_mode,
   input  logic [WORD_W-1:0] ld_word,
   input  logic              cfg_wr_en,
   input  logic [WORD_W-1:0] cfg_wr_data,
   output logic [WORD_W-1:0] cfg_word,
   output logic              test_req,
   output logic [DLY_W-1:0]  test_dly,
   input  logic              test_done,
   input  logic              test_pass,
   output logic [WORD_W-1:0] active_word,
   output logic [DLY_W-1:0]  best_dly,
   output logic              tune_err,
   output logic              busy,
   output logic              tune_done
);

   localparam int               LEN_W   = DLY_W + 1;
   localparam logic [DLY_W-1:0] LAST    = '1;
   localparam logic [WORD_W-1:0] FLD_ONE = WORD_W'((1 << DLY_W) - 1);

   // ---------------- elaboration checks ----------------
   if (DLY_W < 1 || DLY_W > 16) begin : g_bad_dly
      $error("sweep_tuner: DLY_W out of range");
   end
   if (CMD_LSB + DLY_W > WORD_W || DATA_LSB + DLY_W > WORD_W) begin : g_bad_fld
      $error("sweep_tuner: delay field outside the word");
   end
   if ((CMD_LSB < DATA_LSB + DLY_W) && (DATA_LSB < CMD_LSB + DLY_W)) begin : g_overlap
      $error("sweep_tuner: command and data fields overlap");
   end
   if (COMP_LSB + COMP_W > WORD_W) begin : g_bad_comp
      $error("sweep_tuner: compensation field outside the word");
   end
   if (NUM_MODES < 1) begin : g_bad_modes
      $error("sweep_tuner: NUM_MODES must be positive");
   end

   // ---------------- state ----------------
   tune_state_e       state_q;
   logic [MODE_W-1:0] mode_q;
   field_sel_e        fsel_q;
   logic [DLY_W-1:0]  idx_q;
   logic [WORD_W-1:0] base_q;
   logic [WORD_W-1:0] active_q;
   logic [WORD_W-1:0] cfg_q;
   logic [DLY_W-1:0]  best_q;
   logic              err_q;
   logic              req_q;
   logic              done_q;

   logic [WORD_W-1:0] rd_word;
   logic [WORD_W-1:0] trial_word;
   logic [WORD_W-1:0] final_word;
   logic              win_found;
   logic [DLY_W-1:0]  win_mid;
   logic              store_we;
   logic [MODE_W-1:0] store_idx;
   logic [WORD_W-1:0] store_word;
   logic              finishing;
   logic              idle;

   assign idle      = (state_q == ST_IDLE);
   assign finishing = (state_q == ST_FINISH);

   // ---------------- per-mode word table ----------------
   assign store_we   = (finishing && win_found) || (ld_en && idle);
   assign store_idx  = finishing ? mode_q     : ld_mode;
   assign store_word = finishing ? final_word : ld_word;

   sweep_tuner_store #(
      .NUM_MODES (NUM_MODES),
      .WORD_W    (WORD_W),
      .MODE_W    (MODE_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (store_we),
      .wr_idx  (store_idx),
      .wr_word (store_word),
      .rd_idx  (mode_q),
      .rd_word (rd_word)
   );

   // ---------------- field insertion ----------------
   sweep_tuner_field #(
      .WORD_W   (WORD_W),
      .DLY_W    (DLY_W),
      .CMD_LSB  (CMD_LSB),
      .DATA_LSB (DATA_LSB)
   ) u_trial_fld (
      .word_in  (base_q),
      .dly      (idx_q),
      .use_data (fsel_q == FLD_DATA),
      .word_out (trial_word)
   );

   sweep_tuner_field #(
      .WORD_W   (WORD_W),
      .DLY_W    (DLY_W),
      .CMD_LSB  (CMD_LSB),
      .DATA_LSB (DATA_LSB)
   ) u_final_fld (
      .word_in  (base_q),
      .dly      (win_mid),
      .use_data (fsel_q == FLD_DATA),
      .word_out (final_word)
   );

   // ---------------- passing-window tracker ----------------
   sweep_tuner_window #(
      .DLY_W (DLY_W),
      .LEN_W (LEN_W)
   ) u_window (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state_q == ST_LOAD),
      .step  ((state_q == ST_WAIT) && test_done),
      .pass  (test_pass),
      .idx   (idx_q),
      .found (win_found),
      .mid   (win_mid)
   );

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         mode_q   <= '0;
         fsel_q   <= FLD_CMD;
         idx_q    <= '0;
         base_q   <= '0;
         active_q <= '0;
         cfg_q    <= '0;
         best_q   <= '0;
         err_q    <= 1'b0;
         req_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  mode_q                       <= mode_sel;
                  fsel_q                       <= field_sel_e'(tune_data);
                  cfg_q[COMP_LSB +: COMP_W]    <= '0;
                  state_q                      <= ST_LOAD;
               end else if (cfg_wr_en) begin
                  cfg_q <= cfg_wr_data;
               end
            end
            ST_LOAD: begin
               base_q   <= rd_word;
               active_q <= rd_word;
               idx_q    <= '0;
               state_q  <= ST_ISSUE;
            end
            ST_ISSUE: begin
               active_q <= trial_word;
               req_q    <= 1'b1;
               state_q  <= ST_WAIT;
            end
            ST_WAIT: begin
               if (test_done) begin
                  req_q <= 1'b0;
                  if (idx_q == LAST) begin
                     state_q <= ST_FINISH;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= ST_ISSUE;
                  end
               end
            end
            ST_FINISH: begin
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
               if (win_found) begin
                  active_q <= final_word;
                  best_q   <= win_mid;
                  err_q    <= 1'b0;
               end else begin
                  active_q <= base_q;
                  best_q   <= '0;
                  err_q    <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cfg_word    = cfg_q;
   assign test_req    = req_q;
   assign test_dly    = idx_q;
   assign active_word = active_q;
   assign best_dly    = best_q;
   assign tune_err    = err_q;
   assign busy        = !idle;
   assign tune_done   = done_q;

   // ---------------- assertions ----------------
   logic [WORD_W-1:0] keep_mask;
   assign keep_mask = ~(FLD_ONE << ((fsel_q == FLD_DATA) ? DATA_LSB : CMD_LSB));

   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (test_req && !test_done) |=> (test_req && $stable(test_dly)));

   p_dly_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (test_req && test_done && (test_dly != LAST)) |=>
         (!test_req && (test_dly == DLY_W'($past(test_dly) + 1'b1))));

   p_keep_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      test_req |-> ((active_word & keep_mask) == (base_q & keep_mask)));

   p_comp_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cfg_word[COMP_LSB +: COMP_W] == '0));

   p_err_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tune_done && tune_err) |-> (active_word == base_q));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tune_done |-> (!busy && !test_req) ##1 !tune_done);

endmodule

// File: tb/sweep_tuner_tb.sv
module sweep_tuner_tb;

   localparam int CLK_PERIOD = 10;
   localparam int STEPS      = 256;
   localparam int NMODES     = 9;
   localparam int WDOG       = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        tune_data = 1'b0;
   logic [3:0]  mode_sel = '0;
   logic        ld_en = 1'b0;
   logic [3:0]  ld_mode = '0;
   logic [31:0] ld_word = '0;
   logic        cfg_wr_en = 1'b0;
   logic [31:0] cfg_wr_data = '0;
   logic [31:0] cfg_word;
   logic        test_req;
   logic [7:0]  test_dly;
   logic        test_done = 1'b0;
   logic        test_pass = 1'b0;
   logic [31:0] active_word;
   logic [7:0]  best_dly;
   logic        tune_err;
   logic        busy;
   logic        tune_done;

   int          checks = 0;
   int          failures = 0;
   bit          finished = 0;
   logic [31:0] exp_tbl [NMODES];
   logic [31:0] exp_cfg = '0;
   bit          pat [STEPS];

   always #(CLK_PERIOD/2) clk = ~clk;

   sweep_tuner u_dut (
      .clk (clk), .rst_n (rst_n), .start (start), .tune_data (tune_data),
      .mode_sel (mode_sel), .ld_en (ld_en), .ld_mode (ld_mode), .ld_word (ld_word),
      .cfg_wr_en (cfg_wr_en), .cfg_wr_data (cfg_wr_data), .cfg_word (cfg_word),
      .test_req (test_req), .test_dly (test_dly), .test_done (test_done),
      .test_pass (test_pass), .active_word (active_word), .best_dly (best_dly),
      .tune_err (tune_err), .busy (busy), .tune_done (tune_done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] ins_field(input logic [31:0] w, input int d, input bit dm);
      logic [31:0] r = w;
      if (dm) r[23:16] = d[7:0];
      else    r[15:8]  = d[7:0];
      return r;
   endfunction

   // expected choice: scan with a failing sentinel after the last index
   task automatic exp_best(output bit ok, output int mid);
      int bl = 0, be = 0, run = 0;
      for (int i = 0; i <= STEPS; i++) begin
         bit p = (i < STEPS) ? pat[i] : 1'b0;
         if (p) run++;
         else begin
            if (run > bl) begin bl = run; be = i - 1; end
            run = 0;
         end
      end
      ok  = (bl > 0);
      mid = ok ? be - (bl - 1) / 2 : 0;
   endtask

   task automatic fill(input int lo, input int hi, input bit v);
      for (int i = lo; i <= hi; i++) pat[i] = v;
   endtask

   task automatic fill_random();
      int i = 0;
      while (i < STEPS) begin
         int len = 1 + int'($urandom % 40);
         bit v = bit'($urandom % 2);
         for (int k = 0; k < len && i < STEPS; k++) begin pat[i] = v; i++; end
      end
   endtask

   task automatic load_mode(input int m, input logic [31:0] w);
      @(negedge clk);
      ld_en = 1'b1; ld_mode = 4'(m); ld_word = w;
      @(negedge clk);
      ld_en = 1'b0;
      exp_tbl[m] = w;
   endtask

   task automatic run_sweep(input int m, input bit dm, input bit poke, input string tag);
      bit ok; int mid; int n = 0; bit seen = 0;
      int bad_dly = 0, bad_word = 0, guard = 0;
      logic [31:0] base = exp_tbl[m];
      logic [31:0] expw;
      exp_best(ok, mid);
      @(negedge clk);
      mode_sel = 4'(m); tune_data = dm; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      exp_cfg[27:24] = 4'h0;
      check(busy === 1'b1, "R10", {tag, " busy after start"}, 64'(busy), 1);
      check(cfg_word === exp_cfg, "R4", {tag, " compensation cleared"}, 64'(cfg_word), 64'(exp_cfg));
      while (!seen && guard < 4000) begin
         @(negedge clk);
         guard++;
         if (tune_done) seen = 1;
         else if (test_req) begin
            int lat = int'($urandom % 3);
            if (test_dly !== 8'(n)) bad_dly++;
            if (active_word !== ins_field(base, n, dm)) bad_word++;
            if (poke && n == 5) begin
               start = 1'b1; mode_sel = 4'((m + 1) % NMODES);
               ld_en = 1'b1; ld_mode = 4'((m + 1) % NMODES); ld_word = 32'hDEAD_BEEF;
               @(negedge clk);
               start = 1'b0; ld_en = 1'b0;
            end
            repeat (lat) @(negedge clk);
            test_done = 1'b1; test_pass = pat[n];
            @(negedge clk);
            test_done = 1'b0; test_pass = 1'b0;
            n++;
         end
      end
      check(n == STEPS, "R2", {tag, " request count"}, 64'(n), STEPS);
      check(bad_dly == 0, "R2", {tag, " delay order mismatches"}, 64'(bad_dly), 0);
      check(bad_word == 0, "R3", {tag, " trial word mismatches"}, 64'(bad_word), 0);
      check(tune_err === !ok, ok ? "R8" : "R7", {tag, " error flag"}, 64'(tune_err), 64'(!ok));
      expw = ok ? ins_field(base, mid, dm) : base;
      check(best_dly === 8'(mid), ok ? "R5" : "R7", {tag, " chosen delay"}, 64'(best_dly), 64'(mid));
      check(active_word === expw, ok ? "R8" : "R7", {tag, " active word"}, 64'(active_word), 64'(expw));
      if (ok) exp_tbl[m] = expw;
      @(negedge clk);
      check(tune_done === 1'b0 && busy === 1'b0, "R10", {tag, " done pulse ends"},
            64'({tune_done, busy}), 0);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cfg_word === '0 && active_word === '0, "R1", "reset words",
            64'({cfg_word, active_word}), 0);
      check({test_req, test_dly, best_dly, tune_err, busy, tune_done} === '0, "R1",
            "reset controls", 64'({test_req, test_dly, best_dly, tune_err, busy, tune_done}), 0);

      // configuration write while idle
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_data = 32'hFFFF_FFFF;
      @(negedge clk);
      cfg_wr_en = 1'b0; exp_cfg = 32'hFFFF_FFFF;
      check(cfg_word === exp_cfg, "R4", "cfg write", 64'(cfg_word), 64'(exp_cfg));

      for (int m = 0; m < NMODES; m++) load_mode(m, $urandom);

      // R6: all pass, run open at the top, centre 128
      fill(0, 255, 1'b1);
      run_sweep(0, 1'b0, 1'b0, "all-pass");
      // R7: nothing passes
      fill(0, 255, 1'b0);
      run_sweep(1, 1'b1, 1'b0, "all-fail");
      // R5: equal runs 10..19 and 100..109, earliest wins -> 15
      fill(0, 255, 1'b0); fill(10, 19, 1'b1); fill(100, 109, 1'b1);
      run_sweep(2, 1'b0, 1'b0, "tie");
      // R6: open run 200..255 longer than 0..49 -> 228
      fill(0, 255, 1'b0); fill(0, 49, 1'b1); fill(200, 255, 1'b1);
      run_sweep(2, 1'b1, 1'b0, "open-end");
      // single passes at the edges
      fill(0, 255, 1'b0); pat[0] = 1'b1;
      run_sweep(4, 1'b0, 1'b0, "single-low");
      fill(0, 255, 1'b0); pat[255] = 1'b1;
      run_sweep(4, 1'b1, 1'b0, "single-high");
      // R7 again: stored word of mode 1 still untouched
      fill(0, 255, 1'b0);
      run_sweep(1, 1'b0, 1'b0, "all-fail-again");

      // random patterns; one sweep pokes start and a table load while busy (R9, R10)
      for (int k = 0; k < 10; k++) begin
         int m = int'($urandom % NMODES);
         fill_random();
         run_sweep(m, bit'($urandom % 2), k == 3, $sformatf("rand%0d", k));
         if (k == 3) begin
            // the ignored load must not show up in the neighbour's trial words (R9)
            fill_random();
            run_sweep((m + 1) % NMODES, 1'b0, 1'b0, "after-poke");
         end
      end

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule